// File: doc/BRIEF.md
# Multiprocessor-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port with a character format and bit timing that are set by configuration inputs. The transmit side has a one-character holding register in front of a shift register. A host or a DMA channel writes a character into the holding register while the previous one is still shifting out. The holding-register-empty output serves as both status and data request.

The receive side watches the incoming line and checks each start bit. It samples the rest of the frame at the bit centres. Each decoded character goes into a four-entry FIFO together with its own error flags. The format can have 7 or 8 data bits, an optional multiprocessor address/data marker bit, optional even or odd parity, and one or two stop bits. The bit period is 1, 16 or 64 clock cycles.

Top module: `async_serial_port`

## Requirements
- R1: Idle `txd` is 1. A frame is sent as a 0 start bit, then the data bits least significant first (7 when `cfg_len8`=0, 8 when 1), then the marker bit `tx_mp` if `cfg_mp_en`=1, then the parity bit if enabled, then one stop bit of 1 (two when `cfg_two_stop`=1). Each bit lasts N clocks, where `cfg_div` 00 gives N=1, 01 gives N=16, and 10 or 11 give N=64.
- R2: `cfg_parity` 01 selects even parity, 10 selects odd parity, and 00 or 11 send no parity bit. The parity bit covers the data bits and the marker bit (when enabled). With even parity the total number of ones in data, marker and parity is even; with odd parity it is odd.
- R3: `tx_hold_empty` is 1 while the holding register is free. A `tx_wr` pulse while it is 1 captures `tx_data` and `tx_mp`. The held character moves into the shifter when the shifter is idle, or in the last cycle of the final stop bit, so frames follow with no idle gap. A `tx_wr` while `tx_hold_empty` is 0 is ignored.
- R4: The receiver decodes the same format. In 7-bit mode `rx_data[7]` reads 0. `rx_mp` gives the received marker bit, and reads 0 when the marker is disabled.
- R5: When N is 16 or 64, a falling edge on `rxd` is checked again at half a bit period. If the line is high again by then, nothing is received. When N is 1, a low line starts a frame, and each later bit is sampled once.
- R6: `rx_par_err` is set on an entry whose received parity does not match the configured mode.
- R7: `rx_frm_err` is set on an entry if any stop bit was sampled as 0. The data is still stored.
- R8: The FIFO holds up to four entries in arrival order. `rx_avail` is 1 while it is not empty. The oldest entry is shown on `rx_data`, `rx_mp`, `rx_par_err`, `rx_frm_err` and `rx_ovr_err`. An `rx_rd` pulse removes that entry.
- R9: A character that completes while the FIFO is full, and is not met by a read in the same cycle, is discarded. `rx_ovr_err` is then set on the most recently stored entry.
- R10: After reset `txd` is 1, `tx_hold_empty` is 1 and `rx_avail` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_mp_en | input | 1 | Adds the multiprocessor marker bit |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_parity | input | 2 | 01 even, 10 odd, 00 or 11 none |
| cfg_div | input | 2 | Bit period: 00 → 1, 01 → 16, 1x → 64 clocks |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 8 | Character to send |
| tx_mp | input | 1 | Marker bit value to send |
| tx_hold_empty | output | 1 | Holding register free; data request |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Removes the oldest FIFO entry |
| rx_avail | output | 1 | FIFO not empty; receive request |
| rx_data | output | 8 | Oldest received character |
| rx_mp | output | 1 | Marker bit of the oldest entry |
| rx_par_err | output | 1 | Parity error of the oldest entry |
| rx_frm_err | output | 1 | Framing error of the oldest entry |
| rx_ovr_err | output | 1 | Overrun flag of the oldest entry |

## Verification
The assertions assume the configuration inputs do not change while a frame is being sent or received. They also assume `tx_wr` and `rx_rd` are single-cycle strobes. The stimulus changes the configuration only when both the shifter and the FIFO are idle and empty, and it drives every strobe for exactly one cycle, away from the clock edge.

The receive checks in loopback assume both sides use the same bit period. The error tests drive `rxd` directly, one bit per cycle, in divide-by-1 mode.

// File: rtl/asp_pkg.sv
// Shared types and helpers for the asynchronous serial port.
// Assumes: character width of at most 8 bits, frames of at most 13 bits.
package asp_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 13;   // start + 8 data + marker + parity + 2 stop
    localparam int RXBIT_W = 12;   // frame bits after the start bit

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mp;
        logic              perr;
        logic              ferr;
        logic              oerr;
    } rx_entry_t;

    // Clocks per bit for a divide-mode code
    function automatic logic [6:0] div_ratio(input logic [1:0] mode);
        case (mode)
            2'b00:   return 7'd1;
            2'b01:   return 7'd16;
            default: return 7'd64;
        endcase
    endfunction

    // Parity bit enabled for a parity-mode code
    function automatic logic par_enabled(input logic [1:0] mode);
        return mode == 2'b01 || mode == 2'b10;
    endfunction

    // Total frame length in bits including the start bit
    function automatic logic [3:0] frame_len(input logic len8, input logic mp,
                                             input logic par, input logic two);
        return 4'd1 + (len8 ? 4'd8 : 4'd7) + {3'b0, mp} + {3'b0, par}
               + (two ? 4'd2 : 4'd1);
    endfunction

endpackage

// File: rtl/asp_tx.sv
// Transmit path: a holding register feeding a frame shift register.
// Assumes: configuration is stable while a frame is in flight.
module asp_tx
    import asp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_len8,
    input  logic              cfg_mp_en,
    input  logic              cfg_two_stop,
    input  logic [1:0]        cfg_parity,
    input  logic [1:0]        cfg_div,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wmp,
    output logic              hold_empty,
    output logic              txd,
    output logic              load,
    output logic              busy
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_d;
    logic              hold_mp;
    logic [FRAME_W-1:0] shreg;
    logic [FRAME_W-1:0] frame;
    logic [3:0]        left;
    logic [6:0]        cnt;
    logic [6:0]        ratio;
    logic              par_on;
    logic              last_cyc;

    assign ratio      = div_ratio(cfg_div);
    assign par_on     = par_enabled(cfg_parity);
    assign last_cyc   = busy && cnt == 7'd0 && left == 4'd0;
    assign load       = hold_full && (!busy || last_cyc);
    assign hold_empty = !hold_full;
    assign txd        = shreg[0];

    // Assemble the frame for the held character
    always_comb begin
        logic [3:0] pos;
        logic       ones;
        frame    = '1;
        frame[0] = 1'b0;
        pos      = 4'd1;
        ones     = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < DATA_W - 1 || cfg_len8) begin
                frame[pos] = hold_d[i];
                ones       = ones ^ hold_d[i];
                pos        = pos + 4'd1;
            end
        end
        if (cfg_mp_en) begin
            frame[pos] = hold_mp;
            ones       = ones ^ hold_mp;
            pos        = pos + 4'd1;
        end
        if (par_on) begin
            frame[pos] = (cfg_parity == 2'b01) ? ones : ~ones;
        end
    end

    // Shift the frame out, one bit every ratio clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= 4'd0;
            cnt   <= 7'd0;
            busy  <= 1'b0;
        end else if (load) begin
            shreg <= frame;
            left  <= frame_len(cfg_len8, cfg_mp_en, par_on, cfg_two_stop) - 4'd1;
            cnt   <= ratio - 7'd1;
            busy  <= 1'b1;
        end else if (busy) begin
            if (cnt == 7'd0) begin
                shreg <= {1'b1, shreg[FRAME_W-1:1]};
                cnt   <= ratio - 7'd1;
                if (left == 4'd0) busy <= 1'b0;
                else              left <= left - 4'd1;
            end else begin
                cnt <= cnt - 7'd1;
            end
        end
    end

    // Holding register: accept a write only when free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_d    <= '0;
            hold_mp   <= 1'b0;
        end else if (load) begin
            hold_full <= 1'b0;
        end else if (wr && !hold_full) begin
            hold_full <= 1'b1;
            hold_d    <= wdata;
            hold_mp   <= wmp;
        end
    end

endmodule

// File: rtl/asp_rx.sv
// Receive path: start-bit check, centre sampling and frame decode.
// Assumes: rxd is already synchronised to clk; configuration is stable.
module asp_rx
    import asp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_len8,
    input  logic      cfg_mp_en,
    input  logic      cfg_two_stop,
    input  logic [1:0] cfg_parity,
    input  logic [1:0] cfg_div,
    input  logic      rxd,
    output logic      done,
    output rx_entry_t entry
);

    typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} rx_state_t;

    rx_state_t          state;
    logic [6:0]         cnt;
    logic [3:0]         idx;
    logic [RXBIT_W-1:0] bits;
    logic [RXBIT_W-1:0] nb;
    logic [6:0]         ratio;
    logic               par_on;
    logic [3:0]         need;
    logic [3:0]         dlen;
    logic [3:0]         par_pos;
    logic [3:0]         stop_pos;
    rx_entry_t          dec;

    assign ratio    = div_ratio(cfg_div);
    assign par_on   = par_enabled(cfg_parity);
    assign need     = frame_len(cfg_len8, cfg_mp_en, par_on, cfg_two_stop) - 4'd1;
    assign dlen     = cfg_len8 ? 4'd8 : 4'd7;
    assign par_pos  = dlen + {3'b0, cfg_mp_en};
    assign stop_pos = par_pos + {3'b0, par_on};

    // Decode the frame including the bit being sampled now
    always_comb begin
        logic ones;
        nb        = bits;
        nb[idx]   = rxd;
        dec.data  = {cfg_len8 & nb[7], nb[6:0]};
        dec.mp    = cfg_mp_en & nb[dlen];
        ones      = ^dec.data ^ dec.mp ^ nb[par_pos];
        dec.perr  = par_on && (ones != (cfg_parity == 2'b10));
        dec.ferr  = !nb[stop_pos] || (cfg_two_stop && !nb[stop_pos + 4'd1]);
        dec.oerr  = 1'b0;
    end

    // Frame sequencer: hunt, confirm start, then sample each bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= 7'd0;
            idx   <= 4'd0;
            bits  <= '1;
            done  <= 1'b0;
            entry <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (!rxd) begin
                    idx <= 4'd0;
                    if (ratio == 7'd1) begin
                        state <= S_BITS;
                        cnt   <= 7'd0;
                    end else begin
                        state <= S_START;
                        cnt   <= {1'b0, ratio[6:1]} - 7'd1;
                    end
                end
                S_START: if (cnt == 7'd0) begin
                    if (!rxd) begin
                        state <= S_BITS;
                        cnt   <= ratio - 7'd1;
                    end else begin
                        state <= S_IDLE;
                    end
                end else begin
                    cnt <= cnt - 7'd1;
                end
                default: if (cnt == 7'd0) begin
                    bits <= nb;
                    cnt  <= ratio - 7'd1;
                    if (idx == need - 4'd1) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                        entry <= dec;
                    end else begin
                        idx <= idx + 4'd1;
                    end
                end else begin
                    cnt <= cnt - 7'd1;
                end
            endcase
        end
    end

endmodule

// File: rtl/asp_rx_fifo.sv
// Receive FIFO of characters with per-entry status; marks overrun on the newest entry.
// Assumes: pop is a one-cycle strobe; a pop on an empty FIFO is ignored.
module asp_rx_fifo
    import asp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t pentry,
    input  logic      pop,
    output rx_entry_t head,
    output logic      avail,
    output logic      full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp;
    logic [AW-1:0]   rp;
    logic [AW-1:0]   newest;
    logic            do_pop;
    logic            do_push;
    logic            ovr;

    assign full    = count == CW'(DEPTH);
    assign avail   = count != '0;
    assign do_pop  = pop && avail;
    assign do_push = push && (!full || do_pop);
    assign ovr     = push && full && !do_pop;
    assign newest  = (wp == '0) ? AW'(DEPTH - 1) : wp - AW'(1);
    assign head    = mem[rp];

    // Storage writes and overrun marking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) mem[wp] <= pentry;
            if (ovr)     mem[newest].oerr <= 1'b1;
        end
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

endmodule

// File: rtl/async_serial_port.sv
// Top level of the asynchronous serial port: transmitter, receiver with input
// synchroniser, and receive FIFO. Assumes configuration changes only while idle.
module async_serial_port
    import asp_pkg::*;
#(
    parameter int FIFO_DEPTH  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_len8,
    input  logic       cfg_mp_en,
    input  logic       cfg_two_stop,
    input  logic [1:0] cfg_parity,
    input  logic [1:0] cfg_div,
    input  logic       tx_wr,
    input  logic [7:0] tx_data,
    input  logic       tx_mp,
    output logic       tx_hold_empty,
    output logic       txd,
    input  logic       rxd,
    input  logic       rx_rd,
    output logic       rx_avail,
    output logic [7:0] rx_data,
    output logic       rx_mp,
    output logic       rx_par_err,
    output logic       rx_frm_err,
    output logic       rx_ovr_err
);

    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [SYNC_STAGES-1:0] rx_sync;
    logic                   rxd_s;
    logic                   tx_load;
    logic                   tx_busy;
    logic                   rx_push;
    rx_entry_t              rx_new;
    rx_entry_t              rx_head;
    logic                   fifo_full;
    logic [CW-1:0]          fifo_count;

    // Bring the asynchronous line into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) rx_sync <= '1;
        else        rx_sync <= {rx_sync[SYNC_STAGES-2:0], rxd};
    end
    assign rxd_s = rx_sync[SYNC_STAGES-1];

    asp_tx u_tx (
        .clk, .rst_n, .cfg_len8, .cfg_mp_en, .cfg_two_stop, .cfg_parity, .cfg_div,
        .wr(tx_wr), .wdata(tx_data), .wmp(tx_mp),
        .hold_empty(tx_hold_empty), .txd(txd), .load(tx_load), .busy(tx_busy)
    );

    asp_rx u_rx (
        .clk, .rst_n, .cfg_len8, .cfg_mp_en, .cfg_two_stop, .cfg_parity, .cfg_div,
        .rxd(rxd_s), .done(rx_push), .entry(rx_new)
    );

    asp_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk, .rst_n, .push(rx_push), .pentry(rx_new), .pop(rx_rd),
        .head(rx_head), .avail(rx_avail), .full(fifo_full), .count(fifo_count)
    );

    assign rx_data    = rx_head.data;
    assign rx_mp      = rx_head.mp;
    assign rx_par_err = rx_head.perr;
    assign rx_frm_err = rx_head.ferr;
    assign rx_ovr_err = rx_head.oerr;

endmodule

// File: rtl/asp_checker.sv
// Protocol checker for the asynchronous serial port, bound into the top.
module asp_checker #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          txd,
    input logic          tx_wr,
    input logic          tx_hold_empty,
    input logic          tx_load,
    input logic          tx_busy,
    input logic          rx_push,
    input logic          rx_rd,
    input logic          rx_avail,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_count
);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !txd);

    assert_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    assert_write_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_hold_empty) |=> !tx_hold_empty);

    assert_hold_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_hold_empty && !tx_load) |=> !tx_hold_empty);

    assert_empty_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_avail && !rx_push) |=> !rx_avail);

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !rx_rd && !fifo_full) |=> fifo_count == $past(fifo_count) + CW'(1));

    assert_overrun_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && fifo_full && !rx_rd) |=> (fifo_full && $stable(fifo_count)));

endmodule

bind async_serial_port asp_checker #(.CW(CW)) u_asp_checker (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_wr(tx_wr),
    .tx_hold_empty(tx_hold_empty), .tx_load(tx_load), .tx_busy(tx_busy),
    .rx_push(rx_push), .rx_rd(rx_rd), .rx_avail(rx_avail),
    .fifo_full(fifo_full), .fifo_count(fifo_count)
);

// File: tb/test_async_serial_port.sv
// Self-checking bench: sweeps every format and divide mode in loopback,
// then covers double buffering, overrun, receive errors and start rejection.
module test_async_serial_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_len8 = 1'b1, cfg_mp_en = 1'b0, cfg_two_stop = 1'b0;
    logic [1:0] cfg_parity = 2'b00, cfg_div = 2'b00;
    logic       tx_wr = 1'b0, tx_mp = 1'b0, rx_rd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_hold_empty, txd, rxd, rx_avail, rx_mp;
    logic       rx_par_err, rx_frm_err, rx_ovr_err;
    logic [7:0] rx_data;
    logic       loop = 1'b1, rxd_drv = 1'b1;
    int         n_chk = 0, n_bad = 0, cyc = 0;

    assign rxd = loop ? txd : rxd_drv;

    always #2 clk = ~clk;   // 250 MHz

    async_serial_port i_async_serial_port (
        .clk, .rst_n, .cfg_len8, .cfg_mp_en, .cfg_two_stop, .cfg_parity, .cfg_div,
        .tx_wr, .tx_data, .tx_mp, .tx_hold_empty, .txd, .rxd, .rx_rd, .rx_avail,
        .rx_data, .rx_mp, .rx_par_err, .rx_frm_err, .rx_ovr_err
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [1:0] m);
        return (m == 2'b00) ? 1 : (m == 2'b01) ? 16 : 64;
    endfunction

    // Expected line bits of one frame, computed from the format rules
    task automatic build(input logic [7:0] d, input logic m,
                         output logic [12:0] f, output int n);
        int  k = 1;
        logic p = 1'b0;
        f = '1; f[0] = 1'b0;
        for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) begin
            f[k] = d[i]; p = p ^ d[i]; k++;
        end
        if (cfg_mp_en) begin f[k] = m; p = p ^ m; k++; end
        if (cfg_parity == 2'b01 || cfg_parity == 2'b10) begin
            f[k] = (cfg_parity == 2'b01) ? p : ~p; k++;
        end
        n = k + (cfg_two_stop ? 2 : 1);
    endtask

    task automatic write_tx(input logic [7:0] d, input logic m);
        while (!tx_hold_empty) @(negedge clk);
        tx_wr = 1'b1; tx_data = d; tx_mp = m;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pop;
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_start;
        int g = 0;
        while (txd !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
    endtask

    // Send one character, compare the line at each bit centre, then the FIFO head
    task automatic send_check(input logic [7:0] d, input logic m);
        logic [12:0] f;
        int n, r, bad;
        build(d, m, f, n);
        r = ratio_of(cfg_div);
        write_tx(d, m);
        wait_start();
        bad = 0;
        for (int c = 0; c < n * r; c++) begin
            if (c % r == r / 2 && txd !== f[c / r]) bad++;
            @(negedge clk);
        end
        chk("R1 R2 frame", bad, 0);
        repeat (2 * r + 8) @(negedge clk);
        chk("R4 R8 receive", {rx_avail, rx_data, rx_mp, rx_par_err, rx_frm_err, rx_ovr_err},
            {1'b1, cfg_len8 ? d : {1'b0, d[6:0]}, cfg_mp_en & m, 3'b000});
        pop();
    endtask

    // Drive a raw frame onto rxd in divide-by-1 mode
    task automatic drive_raw(input logic [12:0] f, input int n);
        for (int i = 0; i < n; i++) begin
            rxd_drv = f[i];
            @(negedge clk);
        end
        rxd_drv = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=<190000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [12:0] f;
        int n, idx;
        logic [7:0] dv [5];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 idle", {txd, tx_hold_empty, rx_avail}, 3'b110);

        // R1 R2 R4: sweep every format in loopback
        idx = 0;
        for (int dv_i = 0; dv_i < 3; dv_i++)
        for (int l8 = 0; l8 < 2; l8++)
        for (int mp = 0; mp < 2; mp++)
        for (int ts = 0; ts < 2; ts++)
        for (int pm = 0; pm < 3; pm++) begin
            cfg_div = 2'(dv_i); cfg_len8 = 1'(l8); cfg_mp_en = 1'(mp);
            cfg_two_stop = 1'(ts); cfg_parity = 2'(pm);
            @(negedge clk);
            send_check(8'((idx * 37 + 11) & 255), 1'(idx & 1));
            idx++;
        end

        // R3: double buffering and back-to-back frames, divide-by-16 8N1
        cfg_div = 2'b01; cfg_len8 = 1'b1; cfg_mp_en = 1'b0;
        cfg_two_stop = 1'b0; cfg_parity = 2'b00;
        @(negedge clk);
        write_tx(8'hA5, 1'b0);
        wait_start();
        chk("R3 hold freed on load", tx_hold_empty, 1'b1);
        tx_wr = 1'b1; tx_data = 8'h3C;
        @(negedge clk);
        tx_wr = 1'b0;
        chk("R3 hold full after write", tx_hold_empty, 1'b0);
        tx_wr = 1'b1; tx_data = 8'hFF;   // must be ignored
        @(negedge clk);
        tx_wr = 1'b0;
        repeat (150) @(negedge clk);
        chk("R3 stop of first frame", txd, 1'b1);
        repeat (16) @(negedge clk);
        chk("R3 no gap before second start", txd, 1'b0);
        repeat (260) @(negedge clk);
        chk("R3 first char", {rx_avail, rx_data}, {1'b1, 8'hA5});
        pop();
        chk("R3 second char", {rx_avail, rx_data}, {1'b1, 8'h3C});
        pop();
        chk("R3 ignored write left no entry", rx_avail, 1'b0);

        // R9: five characters into a four-entry FIFO, divide-by-1
        cfg_div = 2'b00;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            dv[i] = 8'(8'h10 + i * 8'h21);
            write_tx(dv[i], 1'b0);
        end
        repeat (40) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk("R8 R9 entry", {rx_avail, rx_data, rx_ovr_err}, {1'b1, dv[i], 1'(i == 3)});
            pop();
        end
        chk("R9 fifth char dropped", rx_avail, 1'b0);

        // R6: parity error, 8 data bits even parity
        loop = 1'b0;
        cfg_parity = 2'b01;
        @(negedge clk);
        drive_raw({2'b11, 1'b1, 8'h5A, 1'b0}, 11);
        chk("R6 parity error", {rx_avail, rx_data, rx_par_err, rx_frm_err}, {1'b1, 8'h5A, 2'b10});
        pop();
        drive_raw({2'b11, 1'b0, 8'h5A, 1'b0}, 11);
        chk("R6 parity good", {rx_avail, rx_par_err}, 2'b10);
        pop();

        // R7: missing stop bit, then second stop bit low in 7-bit two-stop mode
        cfg_parity = 2'b00;
        @(negedge clk);
        drive_raw({3'b110, 8'h3C, 1'b0}, 10);
        chk("R7 stop low", {rx_avail, rx_data, rx_frm_err}, {1'b1, 8'h3C, 1'b1});
        pop();
        cfg_len8 = 1'b0; cfg_two_stop = 1'b1;
        @(negedge clk);
        drive_raw({3'b101, 7'h55, 1'b0}, 10);
        chk("R7 R4 second stop low", {rx_avail, rx_data, rx_frm_err}, {1'b1, 8'h55, 1'b1});
        pop();

        // R5: short low pulse in divide-by-16 is not a start bit
        cfg_div = 2'b01; cfg_len8 = 1'b1; cfg_two_stop = 1'b0;
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (4) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (300) @(negedge clk);
        chk("R5 glitch rejected", rx_avail, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule